// File: doc/BRIEF.md
# ADC Serial Result Framer

This block sends a 12-bit conversion result over a three-line synchronous serial link made of a clock line, an active-low frame strobe and a data line. A one-cycle start request starts a frame. The start request also begins the conversion, so the word is on the link while the conversion is still running. The converter core model supplies the result with the start request, and the block captures that value. Each frame has sixteen bits. Four zero bits come first, and the result follows with its most significant bit first.

The serial clock comes from the block clock, which stands for the converter clock and may be internal or external. The serial clock runs at half the rate of the block clock. A mode input selects how the serial clock behaves between frames. In gated mode the serial clock stops and is released high, so several devices can share one bus. In free-running mode the serial clock toggles all the time. Each line is open-drain, so the block drives a pull-low enable for each line and an external pull-up gives the high level.

Top module: `adc_serial_framer`

## Requirements
- R1: A frame carries 16 bits in this order: four zeros first, then the captured 12-bit result, most significant bit first. The receiver samples each bit on a falling edge of the serial clock.
- R2: The data line changes only in the block-clock cycle where the serial clock rises. It is stable across every falling edge of the serial clock while the strobe is low.
- R3: The strobe is low for exactly 16 falling edges of the serial clock. It returns high in the cycle after the 16th falling edge.
- R4: The strobe goes low no more than 3 block-clock edges after the edge that samples the start request. A start request waits at most one cycle before its frame begins.
- R5: The serial clock is high when the strobe goes low. The first leading zero is therefore sampled on the first falling edge of the serial clock.
- R6: While a frame is in progress, the serial clock changes level on every block-clock edge, which is half the block-clock rate.
- R7: In gated mode (free_run = 0), the serial clock and data lines are released (they read high) between frames.
- R8: In free-running mode (free_run = 1), the serial clock keeps toggling between frames, and the data line stays released.
- R9: A start request that arrives while a frame is in progress is ignored. It does not start a second frame, and it does not change the bits being sent.
- R10: Each output is a pull-low enable, where 1 drives the line low and 0 releases it. During reset all three lines are released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock (the converter clock) |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_start | input | 1 | One-cycle start request |
| conv_result | input | 12 | Result from the core model, captured with an accepted start request |
| free_run | input | 1 | 1 = free-running serial clock, 0 = gated serial clock |
| sclk_pull | output | 1 | Pull-low enable for the serial clock line |
| strb_pull | output | 1 | Pull-low enable for the frame strobe line |
| sdat_pull | output | 1 | Pull-low enable for the data line |

## Verification
The bench sends a frame for every third result value in gated mode and for every seventh value in free-running mode. The gated sweep catches errors in bit order, in the zero padding and in bit loss. The free-running sweep covers start requests that arrive in either phase of the serial clock, so it tests the one-cycle wait for a rising edge and the strobe latency bound. Other runs send all-ones, all-zeros and alternating result values, which show whether each data change falls on a rising clock edge. A second start request with a different value is sent in the middle of a frame; this shows whether the block ignores it or sends a second frame or a corrupted word. The idle periods after each frame separate gated behaviour from free-running behaviour.

// File: rtl/adc_framer_pkg.sv
package adc_framer_pkg;
  typedef enum logic {
    SCK_GATED = 1'b0,
    SCK_FREE  = 1'b1
  } sck_mode_e;
endpackage

// File: rtl/framer_ctrl.sv
module framer_ctrl #(
  parameter int FRAME_W = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic conv_start,
  input  logic free_run,
  input  logic sck_hi,
  output logic active,
  output logic load,
  output logic shift_en
);
  localparam int CW = $clog2(2 * FRAME_W);
  localparam logic [CW-1:0] LAST = CW'(2 * FRAME_W - 1);

  logic          pend, pend_n, active_n, go, req;
  logic [CW-1:0] cnt, cnt_n;

  always_comb begin
    load     = conv_start & ~active & ~pend;
    req      = load | pend;
    go       = req & (~sck_hi | ~free_run);
    pend_n   = req & ~go;
    active_n = active;
    cnt_n    = cnt;
    if (go) begin
      active_n = 1'b1;
      cnt_n    = '0;
    end else if (active) begin
      cnt_n = cnt + 1'b1;
      if (cnt == LAST) active_n = 1'b0;
    end
    shift_en = active & cnt[0] & (cnt != LAST);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      pend   <= 1'b0;
      cnt    <= '0;
    end else begin
      active <= active_n;
      pend   <= pend_n;
      cnt    <= cnt_n;
    end
  end

  assert_accept_R4: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start && !active && !pend |=> active || pend);
  assert_pend_one_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pend |=> !pend && active);
  assert_ignore_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    active && cnt != LAST |=> active && !pend);
endmodule

// File: rtl/framer_clkgen.sv
module framer_clkgen (
  input  logic clk,
  input  logic rst_n,
  input  logic free_run,
  input  logic active,
  output logic sck_hi
);
  import adc_framer_pkg::*;

  logic sck_n;
  logic run;

  always_comb begin
    run   = (sck_mode_e'(free_run) == SCK_FREE) | active;
    sck_n = run ? ~sck_hi : 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sck_hi <= 1'b1;
    else        sck_hi <= sck_n;
  end

  assert_toggle_in_frame_R6: assert property (@(posedge clk) disable iff (!rst_n)
    active |=> sck_hi != $past(sck_hi));
  assert_gated_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !free_run && !active |=> sck_hi);
endmodule

// File: rtl/framer_shift.sv
module framer_shift #(
  parameter int RES_W = 12,
  parameter int PAD_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             shift_en,
  input  logic [RES_W-1:0] result,
  output logic             msb
);
  localparam int FRAME_W = RES_W + PAD_W;

  logic [FRAME_W-1:0] sreg, sreg_n;

  always_comb begin
    sreg_n = sreg;
    if (load)          sreg_n = {{PAD_W{1'b0}}, result};
    else if (shift_en) sreg_n = {sreg[FRAME_W-2:0], 1'b0};
    msb = sreg[FRAME_W-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sreg <= '0;
    else        sreg <= sreg_n;
  end

  assert_pad_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !msb);
endmodule

// File: rtl/adc_serial_framer.sv
module adc_serial_framer #(
  parameter int RES_W = 12,
  parameter int PAD_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             conv_start,
  input  logic [RES_W-1:0] conv_result,
  input  logic             free_run,
  output logic             sclk_pull,
  output logic             strb_pull,
  output logic             sdat_pull
);
  localparam int FRAME_W = RES_W + PAD_W;

  logic active, load, shift_en, sck_hi, msb;

  framer_ctrl #(.FRAME_W(FRAME_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .conv_start(conv_start), .free_run(free_run),
    .sck_hi(sck_hi), .active(active), .load(load), .shift_en(shift_en)
  );

  framer_clkgen u_clk (
    .clk(clk), .rst_n(rst_n), .free_run(free_run), .active(active),
    .sck_hi(sck_hi)
  );

  framer_shift #(.RES_W(RES_W), .PAD_W(PAD_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(load), .shift_en(shift_en),
    .result(conv_result), .msb(msb)
  );

  always_comb begin
    sclk_pull = ~sck_hi;
    strb_pull = active;
    sdat_pull = active & ~msb;
  end

  assert_data_on_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    active && $past(active) && !$stable(sdat_pull) |-> $rose(sck_hi));
  assert_strobe_starts_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(strb_pull) |-> !sclk_pull);
  assert_data_released_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !strb_pull |-> !sdat_pull);
endmodule

// File: tb/adc_serial_framer_test.sv
module adc_serial_framer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        conv_start = 1'b0;
  logic [11:0] conv_result = '0;
  logic        free_run = 1'b0;
  logic        sclk_pull, strb_pull, sdat_pull;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  adc_serial_framer uut (
    .clk(clk), .rst_n(rst_n), .conv_start(conv_start), .conv_result(conv_result),
    .free_run(free_run), .sclk_pull(sclk_pull), .strb_pull(strb_pull),
    .sdat_pull(sdat_pull)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Sends one frame and checks it. If second != 0, a new start request with a
  // different value is pulsed in the middle of the frame (R9).
  task automatic run_frame(input logic [11:0] val, input bit second);
    logic [15:0] word = '0;
    int lat = -1, nfall = 0, ends = 0;
    bit bad_r2 = 0, bad_r6 = 0, bad_r5 = 0;
    logic p_sck, p_strb, p_dat, sck, strb, dat;
    p_sck = ~sclk_pull; p_strb = ~strb_pull; p_dat = ~sdat_pull;
    @(negedge clk);
    conv_result = val;
    conv_start  = 1'b1;
    for (int c = 1; c <= 60 && ends == 0; c++) begin
      @(negedge clk);
      conv_start = (second && c == 10);
      if (c == 10) conv_result = ~val;
      sck = ~sclk_pull; strb = ~strb_pull; dat = ~sdat_pull;
      if (!strb && p_strb) begin
        lat = c;
        if (!sck) bad_r5 = 1;
      end
      if (!strb && !p_strb) begin
        if (sck == p_sck) bad_r6 = 1;
        if (dat != p_dat && !(sck && !p_sck)) bad_r2 = 1;
      end
      if (!p_strb && p_sck && !sck) begin
        word = {word[14:0], dat};
        nfall++;
      end
      if (strb && !p_strb) ends = c;
      p_sck = sck; p_strb = strb; p_dat = dat;
    end
    conv_start = 1'b0;
    check(lat >= 1 && lat <= 3, "R4 strobe latency", lat, 3);
    check(word == {4'b0, val}, "R1 frame word", int'(word), int'(val));
    check(nfall == 16, "R3 falling edges in frame", nfall, 16);
    check(!bad_r2, "R2 data change only on rising sclk", bad_r2, 0);
    check(!bad_r5, "R5 sclk high at strobe fall", bad_r5, 0);
    check(!bad_r6, "R6 sclk toggles each cycle", bad_r6, 0);
  endtask

  task automatic check_idle(input int n);
    logic p_sck;
    bit bad_line = 0, bad_tog = 0, bad_strb = 0;
    p_sck = ~sclk_pull;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (strb_pull) bad_strb = 1;
      if (sdat_pull) bad_line = 1;
      if (!free_run && sclk_pull) bad_line = 1;
      if (free_run && (~sclk_pull) == p_sck) bad_tog = 1;
      p_sck = ~sclk_pull;
    end
    check(!bad_strb, "R9 no second frame / strobe idle high", bad_strb, 0);
    if (free_run) begin
      check(!bad_line, "R8 data released in free idle", bad_line, 0);
      check(!bad_tog, "R8 sclk toggles in free idle", bad_tog, 0);
    end else begin
      check(!bad_line, "R7 sclk and data released in gated idle", bad_line, 0);
    end
  endtask

  initial begin
    #10000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check({sclk_pull, strb_pull, sdat_pull} == 3'b000, "R10 reset releases lines",
          int'({sclk_pull, strb_pull, sdat_pull}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check({sclk_pull, strb_pull, sdat_pull} == 3'b000, "R10 idle after reset",
          int'({sclk_pull, strb_pull, sdat_pull}), 0);
    // Gated sweep
    for (int v = 0; v < 4096; v += 3) run_frame(12'(v), 1'b0);
    run_frame(12'hFFF, 1'b0);
    run_frame(12'h000, 1'b0);
    run_frame(12'hAAA, 1'b0);
    check_idle(8);
    run_frame(12'h5A3, 1'b1);
    check_idle(40);
    // Free-running sweep, both serial-clock phases at the start request
    free_run = 1'b1;
    for (int v = 0; v < 4096; v += 7) begin
      run_frame(12'(v), 1'b0);
      if (v % 2 == 1) @(negedge clk);
    end
    run_frame(12'h555, 1'b0);
    @(negedge clk);
    run_frame(12'hC3C, 1'b1);
    check_idle(40);
    free_run = 1'b0;
    @(negedge clk);
    check_idle(8);
    run_frame(12'h801, 1'b0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule